// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer

Two 16-bit down-counters that act as one peripheral and are set up through a small register bus. A two-bit mode field sets how the counters work together. In PWM mode counter 0 drives a pulse output and counter 1 is a free timer. In dual capture mode counter 0 is a shared timebase that both event inputs sample. In dual timer mode the two counters run independently. In mixed mode one counter counts events and the other is a system timer whose value the second input captures.

Each counter loads its reload value when it steps from zero, so its period is reload+1 steps. A counter steps on every core clock or on edges of its event input. The event inputs pass through a synchronizer and an edge detector, and each input has its own polarity select. Sticky flags record underflows, captures and capture overruns, and software clears a flag by writing 1 to it. One interrupt line is the OR of every flag that is both set and enabled.

Register map (address: contents). 0 control: [1:0] mode (00 PWM, 01 dual capture, 10 dual timer, 11 capture plus timer), [2] enable 0, [3] enable 1, [4] counter 0 steps on event-0 edges, [5] counter 1 steps on event-1 edges, [6] event 0 falling edge, [7] event 1 falling edge. 1: reload 0. 2: reload 1. 3: PWM compare. 4: capture 0 (a read of this address clears its pending state). 5: capture 1 (same). 6: flags, write 1 to clear: [0] underflow 0, [1] underflow 1, [2] capture 0, [3] capture 1, [4] overrun 0, [5] overrun 1. 7: interrupt enables, with the same bit layout as the flags. 8: counter 0 value (read only). 9: counter 1 value (read only). Reads are combinational.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset every readable register, both counters and all flags read 0, and pwm_out and irq_out are low.
- R2: An enabled counter that steps at zero loads its reload value, and otherwise decrements by 1. In clock-stepped operation the value k clocks after enable is 0 for k=0 and reload-((k-1) mod (reload+1)) after that.
- R3: The underflow flag (bit 0 for counter 0, bit 1 for counter 1) is set when a counter steps from zero. It stays set until a 1 is written to that flag bit.
- R4: In PWM mode with counter 0 enabled, pwm_out is low if compare is 0. Otherwise it is high if compare is at least reload 0, or if counter 0 is above compare. In every other case pwm_out is low.
- R5: In dual timer mode, a counter whose source bit is set steps once per selected edge of its event input and holds when no edge arrives.
- R6: In dual capture mode counter 0 runs on the clock. A selected edge on event 0 stores counter 0 into capture 0, and one on event 1 stores counter 0 into capture 1. The stored value is the one held two clocks after the input changed, and the capture flag is set.
- R7: An input edge of the polarity that is not selected causes no capture and sets no flag.
- R8: A capture that arrives while the previous capture on that channel has not been read sets the overrun flag (bit 4 or 5) and overwrites the capture register.
- R9: In capture plus timer mode counter 0 steps on event-0 edges and counter 1 steps on the clock. Event 1 captures counter 1 into capture 1, and capture 0 is left unchanged.
- R10: A control write that changes the mode clears both counters to 0. A disabled counter holds its value.
- R11: irq_out is high exactly when some flag bit and the matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read clears capture pending state) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ev0_in | input | 1 | External event input 0 |
| ev1_in | input | 1 | External event input 1 |
| pwm_out | output | 1 | Pulse width output |
| irq_out | output | 1 | Interrupt request |

## Verification
A register write takes effect on the clock edge that samples the strobe, and reads return data combinationally in the same cycle. A clock-stepped counter moves on every edge after its enable. Its value k edges after the enabling write follows the R2 formula, and PWM follows that value with no added register. An event input change shows up as a counter step, capture or flag on the third rising edge after the change. The captured value is therefore the counter value visible on the bus two falling edges after the input was driven. The bench drives all inputs on falling edges and samples 1 ns after a falling edge, which places each check in the cycle worked out above.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [1:0] {
    MODE_PWM    = 2'b00,
    MODE_DCAP   = 2'b01,
    MODE_DTMR   = 2'b10,
    MODE_CAPTMR = 2'b11
  } tmr_mode_e;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned FLAG_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_RLD0 = 4'd1;
  localparam logic [ADDR_W-1:0] A_RLD1 = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAP0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP1 = 4'd5;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd6;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_CNT1 = 4'd9;

  localparam int unsigned CB_EN0  = 2;
  localparam int unsigned CB_SRC0 = 4;
  localparam int unsigned CB_POL0 = 6;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edge_o = fall_sel ? (sh_q[STAGES] & ~sh_q[STAGES-1])
                           : (~sh_q[STAGES] & sh_q[STAGES-1]);
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    uf_o  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (en && tick) begin
      if (at_zero) begin
        cnt_d = reload;
        uf_o  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  reload_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !clr && cnt_q == '0) |=> (cnt_q == $past(reload)));
  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));
  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ev0_in,
  input  logic              ev1_in,
  output logic              pwm_out,
  output logic              irq_out
);
  localparam int unsigned NCH = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  logic [CTRL_W-1:0]         ctrl_q;
  logic [NCH-1:0][CNT_W-1:0] rld_q, cap_q, cap_d, cap_src, cnt;
  logic [CNT_W-1:0]          cmp_q;
  logic [FLAG_W-1:0]         flags_q, flags_d, flag_set, w1c, ien_q;
  logic [NCH-1:0]            pend_q, pend_d;
  logic [NCH-1:0]            ev_in, ev_edge, tick, uf, cap_sel, cap_evt, rd_cap, ovr;
  logic                      wr_ctrl, wr_flag, mode_chg;
  tmr_mode_e                 mode;

  assign mode     = tmr_mode_e'(ctrl_q[1:0]);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_flag  = bus_wr && (bus_addr == A_FLAG);
  assign mode_chg = wr_ctrl && (bus_wdata[1:0] != ctrl_q[1:0]);
  assign ev_in    = {ev1_in, ev0_in};
  assign rd_cap   = {bus_rd && (bus_addr == A_CAP1), bus_rd && (bus_addr == A_CAP0)};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n_i), .din(ev_in[g]),
      .fall_sel(ctrl_q[CB_POL0+g]), .edge_o(ev_edge[g]));

    tmr_down_counter #(.W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n_i), .clr(mode_chg), .en(ctrl_q[CB_EN0+g]),
      .tick(tick[g]), .reload(rld_q[g]), .cnt_o(cnt[g]), .uf_o(uf[g]));
  end

  // how the two counters relate in each mode
  always_comb begin
    tick[0]    = 1'b1;
    tick[1]    = ctrl_q[CB_SRC0+1] ? ev_edge[1] : 1'b1;
    cap_sel    = 2'b00;
    cap_src[0] = cnt[0];
    cap_src[1] = cnt[0];
    case (mode)
      MODE_PWM:  ;
      MODE_DCAP: cap_sel = 2'b11;
      MODE_DTMR: tick[0] = ctrl_q[CB_SRC0] ? ev_edge[0] : 1'b1;
      MODE_CAPTMR: begin
        tick[0]    = ev_edge[0];
        tick[1]    = 1'b1;
        cap_sel    = 2'b10;
        cap_src[1] = cnt[1];
      end
      default: ;
    endcase
  end

  always_comb begin
    cap_evt = cap_sel & ev_edge;
    for (int i = 0; i < NCH; i++) begin
      ovr[i]    = cap_evt[i] & pend_q[i] & ~rd_cap[i];
      pend_d[i] = cap_evt[i] | (pend_q[i] & ~rd_cap[i]);
      cap_d[i]  = cap_evt[i] ? cap_src[i] : cap_q[i];
    end
    flag_set = {ovr, cap_evt, uf};
    w1c      = wr_flag ? bus_wdata[FLAG_W-1:0] : '0;
    flags_d  = (flags_q & ~w1c) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q  <= '0;
      rld_q   <= '0;
      cmp_q   <= '0;
      ien_q   <= '0;
      cap_q   <= '0;
      pend_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_ctrl)                        ctrl_q   <= bus_wdata[CTRL_W-1:0];
      if (bus_wr && bus_addr == A_RLD0)   rld_q[0] <= bus_wdata;
      if (bus_wr && bus_addr == A_RLD1)   rld_q[1] <= bus_wdata;
      if (bus_wr && bus_addr == A_CMP)    cmp_q    <= bus_wdata;
      if (bus_wr && bus_addr == A_IEN)    ien_q    <= bus_wdata[FLAG_W-1:0];
      cap_q   <= cap_d;
      pend_q  <= pend_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    pwm_out = 1'b0;
    if (mode == MODE_PWM && ctrl_q[CB_EN0] && cmp_q != '0)
      pwm_out = (cmp_q >= rld_q[0]) || (cnt[0] > cmp_q);
  end

  assign irq_out = |(flags_q & ien_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_RLD0:  bus_rdata = rld_q[0];
      A_RLD1:  bus_rdata = rld_q[1];
      A_CMP:   bus_rdata = cmp_q;
      A_CAP0:  bus_rdata = cap_q[0];
      A_CAP1:  bus_rdata = cap_q[1];
      A_FLAG:  bus_rdata = {{(CNT_W-FLAG_W){1'b0}}, flags_q};
      A_IEN:   bus_rdata = {{(CNT_W-FLAG_W){1'b0}}, ien_q};
      A_CNT0:  bus_rdata = cnt[0];
      A_CNT1:  bus_rdata = cnt[1];
      default: bus_rdata = '0;
    endcase
  end

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (flags_q[0] && !wr_flag) |=> flags_q[0]);
  // R8
  ovr_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(flags_q[4]) |-> $past(pend_q[0]));
endmodule

// File: tb/test_dual_mode_timer.sv
module test_dual_mode_timer;
  import dmt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ev0_in = 1'b0, ev1_in = 1'b0;
  logic        pwm_out, irq_out;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_mode_timer i_dual_mode_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev0_in(ev0_in), .ev1_in(ev1_in), .pwm_out(pwm_out), .irq_out(irq_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d[15:0]; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // drive an event input, return the peeked value two falling edges later
  task automatic stim(input int ch, input logic lvl, input logic [3:0] pa, output int v);
    @(negedge clk);
    bus_addr = pa;
    if (ch == 0) ev0_in = lvl; else ev1_in = lvl;
    @(negedge clk);
    @(negedge clk);
    #1 v = int'(bus_rdata);
    repeat (4) @(negedge clk);
  endtask

  function automatic int model(input int n, input int k);
    return (k == 0) ? 0 : n - ((k - 1) % (n + 1));
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, e, a, b;
    int nlist[5] = '{0, 1, 2, 5, 9};
    int clist[4] = '{0, 3, 7, 9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rd(i[3:0], v);
      chk("R1 reg", v, 0);
    end
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 irq", int'(irq_out), 0);

    // R2 clock-stepped count sweep
    foreach (nlist[j]) begin
      wr(A_CTRL, 0);
      wr(A_RLD0, nlist[j]);
      wr(A_CTRL, 'h06);
      bus_addr = A_CNT0;
      #1 chk("R2 k0", int'(bus_rdata), 0);
      for (int k = 1; k <= 2 * nlist[j] + 4; k++) begin
        @(negedge clk);
        #1 chk("R2 count", int'(bus_rdata), model(nlist[j], k));
      end
    end
    wr(A_CTRL, 'h02);
    rd(A_FLAG, v);
    chk("R3 uf0 set", v & 1, 1);
    chk("R3 uf1 clear", (v >> 1) & 1, 0);
    repeat (3) @(negedge clk);
    rd(A_FLAG, v);
    chk("R3 uf0 sticky", v & 1, 1);
    wr(A_FLAG, 1);
    rd(A_FLAG, v);
    chk("R3 uf0 cleared", v & 1, 0);

    // R4 PWM compare sweep
    foreach (clist[j]) begin
      wr(A_CTRL, 'h02);
      wr(A_CMP, clist[j]);
      wr(A_RLD0, 7);
      wr(A_CTRL, 'h04);
      for (int k = 0; k < 20; k++) begin
        if (k > 0) @(negedge clk);
        #1 chk("R4 pwm", int'(pwm_out),
               int'(clist[j] != 0 && (clist[j] >= 7 || model(7, k) > clist[j])));
      end
    end

    // R5 event-stepped counter 1
    wr(A_CTRL, 0);
    wr(A_RLD1, 3);
    wr(A_CTRL, 'h2A);
    repeat (6) @(negedge clk);
    rd(A_CNT1, v);
    chk("R5 hold without edges", v, 0);
    for (int p = 1; p <= 5; p++) begin
      stim(1, 1'b1, A_CNT1, e);
      stim(1, 1'b0, A_CNT1, e);
      rd(A_CNT1, v);
      chk("R5 event count", v, 3 - ((p - 1) % 4));
    end
    rd(A_FLAG, v);
    chk("R5 uf1 after wrap", (v >> 1) & 1, 1);

    // R6 / R7 dual capture, event 1 on falling edges
    wr(A_CTRL, 0);
    wr(A_RLD0, 1000);
    wr(A_CTRL, 'h85);
    repeat (10) @(negedge clk);
    stim(0, 1'b1, A_CNT0, e);
    rd(A_CAP0, v);
    chk("R6 cap0 value", v, e);
    rd(A_FLAG, v);
    chk("R6 cap0 flag", (v >> 2) & 1, 1);
    stim(1, 1'b1, A_CNT0, e);
    rd(A_FLAG, v);
    chk("R7 rising ignored flag", (v >> 3) & 1, 0);
    rd(A_CAP1, v);
    chk("R7 rising ignored cap1", v, 0);
    stim(1, 1'b0, A_CNT0, e);
    rd(A_CAP1, v);
    chk("R6 cap1 value", v, e);
    rd(A_FLAG, v);
    chk("R6 cap1 flag", (v >> 3) & 1, 1);

    // R8 overrun
    stim(0, 1'b0, A_CNT0, e);
    stim(0, 1'b1, A_CNT0, a);
    rd(A_FLAG, v);
    chk("R8 no overrun after read", (v >> 4) & 1, 0);
    stim(0, 1'b0, A_CNT0, e);
    stim(0, 1'b1, A_CNT0, b);
    rd(A_FLAG, v);
    chk("R8 overrun set", (v >> 4) & 1, 1);
    rd(A_CAP0, v);
    chk("R8 latest capture kept", v, b);
    wr(A_FLAG, 'h10);
    rd(A_FLAG, v);
    chk("R8 overrun cleared", (v >> 4) & 1, 0);

    // R9 capture plus timer
    stim(0, 1'b0, A_CNT0, e);
    wr(A_CTRL, 0);
    wr(A_RLD0, 5);
    wr(A_RLD1, 500);
    wr(A_CTRL, 'h0F);
    stim(0, 1'b1, A_CNT0, e);
    stim(0, 1'b0, A_CNT0, e);
    rd(A_CNT0, v);
    chk("R9 event counter first", v, 5);
    stim(0, 1'b1, A_CNT0, e);
    stim(0, 1'b0, A_CNT0, e);
    rd(A_CNT0, v);
    chk("R9 event counter second", v, 4);
    rd(A_CAP0, v);
    chk("R9 cap0 untouched", v, b);
    stim(1, 1'b1, A_CNT1, e);
    rd(A_CAP1, v);
    chk("R9 cap1 from counter 1", v, e);
    rd(A_CNT1, a);
    rd(A_CNT1, v);
    chk("R9 counter 1 on clock", v, a - 2);

    // R10 mode change clears, disabled counter holds
    wr(A_CTRL, 'h02);
    rd(A_CNT0, v);
    chk("R10 cnt0 cleared", v, 0);
    rd(A_CNT1, v);
    chk("R10 cnt1 cleared", v, 0);
    repeat (5) @(negedge clk);
    rd(A_CNT1, v);
    chk("R10 cnt1 holds", v, 0);

    // R11 interrupt
    wr(A_FLAG, 'h3F);
    rd(A_FLAG, v);
    chk("R11 flags cleared", v, 0);
    wr(A_IEN, 1);
    #1 chk("R11 irq idle", int'(irq_out), 0);
    wr(A_RLD0, 2);
    wr(A_CTRL, 'h06);
    repeat (2) @(negedge clk);
    #1 chk("R11 irq on uf0", int'(irq_out), 1);
    wr(A_CTRL, 'h02);
    wr(A_IEN, 0);
    #1 chk("R11 irq masked", int'(irq_out), 0);
    wr(A_IEN, 1);
    #1 chk("R11 irq unmasked", int'(irq_out), 1);
    wr(A_FLAG, 1);
    #1 chk("R11 irq after clear", int'(irq_out), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule